// File: doc/BRIEF.md
# Dual I/O Window Decoder

This block compares each host I/O cycle's 16-bit port address against two programmable address windows. Each window has a start address and an inclusive stop address. When the host I/O strobe is active and an enabled window contains the address, the block reports a hit. It also reports which window matched and the attributes that window asks for: the effective data width, a zero-wait-state request and the choice of timing set. For the data width, a window either uses a fixed value or copies the 16-bit-select pin that the card drives.

Software programs the windows through a byte-wide indexed register write port. Both windows share one control byte, with one nibble per window. Both windows take their enable bits from a register that also carries enables for other window types. This block stores only its own two enable bits. The decode result is registered, so it appears one clock after the address, strobe and width pin are sampled.

Top module: `dual_io_win_dec`

## Requirements
- R1: After reset, all outputs are 0, and every register (windows, control byte, enables) is 0. With these values, no address produces a hit until software programs the block.
- R2: Window w covers every address a with start ≤ a ≤ stop. The stop value is the last address in the window, so stop hits, stop+1 misses and start−1 misses.
- R3: While `io_strb_i` is low, `hit_o` is 0 in the following cycle. Whenever `hit_o` is 0, `win_o`, `wide_o`, `zws_o` and `tset_o` are all 0.
- R4: Index 0x06 bit 6 enables window 0 and bit 7 enables window 1. A window whose enable bit is 0 never produces a hit, even if the address lies inside it.
- R5: If an address lies in both enabled windows, window 0 wins and `win_o` is 0.
- R6: The control byte is at index 0x07. Window 0 uses bits 3:0 and window 1 uses bits 7:4. Within a nibble, bit 0 selects fixed 16-bit width, bit 1 makes the width follow the card pin, bit 2 requests zero wait states and bit 3 selects timing set 1. `wide_o`, `zws_o` and `tset_o` report the nibble of the winning window.
- R7: When the follow bit of the winning window is 1, `wide_o` equals `iocs16_i` as sampled with the address, and the fixed-width bit has no effect.
- R8: The outputs reflect the address, strobe and width pin sampled at the previous rising clock edge. They do not change before that edge.
- R9: A register write takes effect at the clock edge that captures it. A decode sampled at that same edge uses the values from before the write.
- R10: Window 0 start is at 0x08 (low byte) and 0x09 (high byte), and its stop is at 0x0A and 0x0B. Window 1 uses 0x0C to 0x0F in the same layout. Writes to any other index leave the windows unchanged.
- R11: A window whose start is greater than its stop matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | IDX_W | Register index |
| reg_wdata_i | input | 8 | Register write data |
| io_addr_i | input | 16 | Host I/O address |
| io_strb_i | input | 1 | Host I/O cycle strobe |
| iocs16_i | input | 1 | Card 16-bit-select pin |
| hit_o | output | 1 | Address fell in an enabled window |
| win_o | output | 1 | Index of the matching window |
| wide_o | output | 1 | Effective 16-bit width |
| zws_o | output | 1 | Zero-wait-state request |
| tset_o | output | 1 | Timing set select |

## Verification
A register write and a decode can land on the same clock edge. In that case the decode must use the control values from before the write. The bench provokes this by writing the control byte so that it clears window 0's zero-wait bit, while in the same cycle it strobes an address inside window 0. It then checks that the result still shows the old zero-wait request, and that the decode in the next cycle shows it cleared. A second case makes two windows overlap at their start or stop addresses, and this is judged against the window 0 priority rule.

// File: rtl/diowd_pkg.sv
package diowd_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 2 * DATA_W;
  localparam int NUM_WIN     = 2;
  localparam int NIB_W       = 4;
  localparam int BYTES_PER_W = 4;
  localparam int WIN_IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int IDX_ENA     = 6;
  localparam int IDX_CTRL    = 7;
  localparam int IDX_WBASE   = 8;
  localparam int ENA_LSB     = 6;

  typedef struct packed {
    logic tset;
    logic zws;
    logic follow;
    logic w16;
  } win_attr_t;
endpackage

// File: rtl/diowd_regs.sv
module diowd_regs
  import diowd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    start_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    stop_o,
  output logic [NUM_WIN-1:0]                en_o,
  output win_attr_t [NUM_WIN-1:0]           attr_o
);
  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_WIN-1:0] ena_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ena_q  <= '0;
    end else if (we_i) begin
      if (idx_i == IDX_W'(IDX_CTRL)) ctrl_q <= wdata_i;
      if (idx_i == IDX_W'(IDX_ENA))  ena_q  <= wdata_i[ENA_LSB +: NUM_WIN];
    end
  end

  assign en_o = ena_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [BYTES_PER_W-1:0][DATA_W-1:0] bytes_q;
    for (genvar b = 0; b < BYTES_PER_W; b++) begin : g_byte
      localparam int MY_IDX = IDX_WBASE + BYTES_PER_W * w + b;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)
          bytes_q[b] <= '0;
        else if (we_i && idx_i == IDX_W'(MY_IDX))
          bytes_q[b] <= wdata_i;
      end
    end
    assign start_o[w] = {bytes_q[1], bytes_q[0]};
    assign stop_o[w]  = {bytes_q[3], bytes_q[2]};
    assign attr_o[w]  = win_attr_t'(ctrl_q[w*NIB_W +: NIB_W]);
  end
endmodule

// File: rtl/diowd_cmp.sv
module diowd_cmp
  import diowd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] stop_i,
  input  logic              act_i,
  output logic              match_o
);
  logic above_start;
  logic below_stop;

  assign above_start = (addr_i >= start_i);
  assign below_stop  = (addr_i <= stop_i);
  assign match_o     = act_i && above_start && below_stop;
endmodule

// File: rtl/diowd_sel.sv
module diowd_sel
  import diowd_pkg::*;
(
  input  logic [NUM_WIN-1:0]      match_i,
  input  win_attr_t [NUM_WIN-1:0] attr_i,
  input  logic                    iocs16_i,
  output logic                    hit_o,
  output logic [WIN_IDX_W-1:0]    idx_o,
  output logic                    wide_o,
  output logic                    zws_o,
  output logic                    tset_o
);
  win_attr_t pick;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    pick  = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        hit_o = 1'b1;
        idx_o = WIN_IDX_W'(w);
        pick  = attr_i[w];
      end
    end
  end

  assign wide_o = hit_o && (pick.follow ? iocs16_i : pick.w16);
  assign zws_o  = hit_o && pick.zws;
  assign tset_o = hit_o && pick.tset;
endmodule

// File: rtl/dual_io_win_dec.sv
module dual_io_win_dec
  import diowd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic [15:0]       io_addr_i,
  input  logic              io_strb_i,
  input  logic              iocs16_i,
  output logic              hit_o,
  output logic              win_o,
  output logic              wide_o,
  output logic              zws_o,
  output logic              tset_o
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] start_w;
  logic [NUM_WIN-1:0][ADDR_W-1:0] stop_w;
  logic [NUM_WIN-1:0]             win_en_w;
  win_attr_t [NUM_WIN-1:0]        attr_w;
  logic [NUM_WIN-1:0]             match_w;
  logic                           hit_d, wide_d, zws_d, tset_d;
  logic [WIN_IDX_W-1:0]           idx_d;

  diowd_regs #(.IDX_W(IDX_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .en_o    (win_en_w),
    .attr_o  (attr_w)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    diowd_cmp cmp_i (
      .addr_i  (io_addr_i),
      .start_i (start_w[w]),
      .stop_i  (stop_w[w]),
      .act_i   (io_strb_i && win_en_w[w]),
      .match_o (match_w[w])
    );
  end

  diowd_sel sel_i (
    .match_i  (match_w),
    .attr_i   (attr_w),
    .iocs16_i (iocs16_i),
    .hit_o    (hit_d),
    .idx_o    (idx_d),
    .wide_o   (wide_d),
    .zws_o    (zws_d),
    .tset_o   (tset_d)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      win_o  <= 1'b0;
      wide_o <= 1'b0;
      zws_o  <= 1'b0;
      tset_o <= 1'b0;
    end else begin
      hit_o  <= hit_d;
      win_o  <= idx_d[0];
      wide_o <= wide_d;
      zws_o  <= zws_d;
      tset_o <= tset_d;
    end
  end
endmodule

// File: rtl/diowd_chk.sv
module diowd_chk
  import diowd_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    io_strb_i,
  input logic                    iocs16_i,
  input logic                    hit_o,
  input logic                    win_o,
  input logic                    wide_o,
  input logic                    zws_o,
  input logic                    tset_o,
  input logic [NUM_WIN-1:0]      win_en,
  input win_attr_t [NUM_WIN-1:0] attr
);
  AST_NO_HIT_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_strb_i |=> !hit_o); // R3
  AST_MISS_IS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!win_o && !wide_o && !zws_o && !tset_o)); // R3
  AST_ALL_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_en == '0) |=> !hit_o); // R4
  AST_WIN1_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en[1] |=> !(hit_o && win_o)); // R4
  AST_WIDTH_FOLLOWS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_strb_i && attr[0].follow && attr[1].follow) |=> (!hit_o || wide_o == $past(iocs16_i))); // R7
  AST_ZWS_ONLY_IF_ASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!attr[0].zws && !attr[1].zws) |=> !zws_o); // R6
endmodule

bind dual_io_win_dec diowd_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_strb_i (io_strb_i),
  .iocs16_i  (iocs16_i),
  .hit_o     (hit_o),
  .win_o     (win_o),
  .wide_o    (wide_o),
  .zws_o     (zws_o),
  .tset_o    (tset_o),
  .win_en    (win_en_w),
  .attr      (attr_w)
);

// File: tb/dual_io_win_dec_tb_top.sv
module dual_io_win_dec_tb_top;
  localparam int IDX_W = 6;
  localparam int NV    = 10;
  // {addr[15:0], strb, iocs, hit, win, wide, zws, tset}
  localparam logic [22:0] VEC [NV] = '{
    {16'h0300, 7'b1010110},  // R2 start of window 0
    {16'h02FF, 7'b1000000},  // R2 start-1 misses
    {16'h031F, 7'b1010110},  // R2 stop of window 0, R5 overlap
    {16'h0310, 7'b1110110},  // R5 start of window 1, window 0 wins
    {16'h0320, 7'b1111101},  // R6/R7 window 1 follows pin high
    {16'h0320, 7'b1011001},  // R7 window 1 follows pin low
    {16'h0340, 7'b1011001},  // R2 stop of window 1
    {16'h0341, 7'b1100000},  // R2 stop+1 misses
    {16'h0300, 7'b0100000},  // R3 strobe low
    {16'hFFFF, 7'b1100000}   // R2 far outside
  };

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [IDX_W-1:0] idx = '0;
  logic [7:0] wdata = '0;
  logic [15:0] addr = '0;
  logic strb = 0, iocs = 0;
  logic hit, win, wide, zws, tset;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_io_win_dec #(.IDX_W(IDX_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .io_addr_i(addr), .io_strb_i(strb),
    .iocs16_i(iocs), .hit_o(hit), .win_o(win), .wide_o(wide),
    .zws_o(zws), .tset_o(tset)
  );

  function automatic logic [4:0] outs();
    return {hit, win, wide, zws, tset};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {hit,win,wide,zws,tset} = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [7:0] d);
    @(negedge clk);
    we = 1; idx = IDX_W'(i); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic dec(input logic [15:0] a, input logic s, input logic p,
                     input string req, input logic [4:0] exp);
    @(negedge clk);
    addr = a; strb = s; iocs = p;
    @(negedge clk);
    check(req, outs(), exp);
    strb = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 5'b0);
    rst_n = 1;
    dec(16'h0000, 1, 1, "R1 unprogrammed no hit", 5'b0);

    // window 0: 0x0300..0x031F, window 1: 0x0310..0x0340
    wr(8, 8'h00); wr(9, 8'h03); wr(10, 8'h1F); wr(11, 8'h03);
    wr(12, 8'h10); wr(13, 8'h03); wr(14, 8'h40); wr(15, 8'h03);
    wr(7, 8'hA5);   // win0: zws|w16, win1: tset|follow
    wr(6, 8'hC0);   // enable both

    for (int v = 0; v < NV; v++)
      dec(VEC[v][22:7], VEC[v][6], VEC[v][5], $sformatf("R2 vector %0d", v), VEC[v][4:0]);

    // R4: window 0 disabled
    wr(6, 8'h80);
    dec(16'h0300, 1, 0, "R4 window 0 off", 5'b00000);
    dec(16'h0310, 1, 1, "R4 window 1 still on", 5'b11101);
    wr(6, 8'h40);
    dec(16'h0320, 1, 1, "R4 window 1 off", 5'b00000);
    wr(6, 8'hC0);

    // R7: follow bit overrides fixed width on window 0
    wr(7, 8'hA3);
    dec(16'h0300, 1, 0, "R7 follow low ignores w16", 5'b10000);
    dec(16'h0300, 1, 1, "R7 follow high", 5'b10100);
    wr(7, 8'hA5);

    // R8: no change before the capturing edge
    @(negedge clk);
    addr = 16'h0300; strb = 1; iocs = 0;
    #1 check("R8 before edge", outs(), 5'b00000);
    @(negedge clk);
    check("R8 after edge", outs(), 5'b10110);
    strb = 0;

    // R9: write and decode at the same edge
    @(negedge clk);
    we = 1; idx = IDX_W'(7); wdata = 8'hA0;
    addr = 16'h0300; strb = 1; iocs = 0;
    @(negedge clk);
    we = 0;
    check("R9 same-edge decode uses old ctrl", outs(), 5'b10110);
    @(negedge clk);
    check("R9 next decode uses new ctrl", outs(), 5'b10000);
    strb = 0;
    wr(7, 8'hA5);

    // R10: stray index write, then window 0 stop high byte
    wr(16, 8'hFF);
    wr(5, 8'hFF);
    dec(16'h0300, 1, 0, "R10 stray writes leave windows", 5'b10110);
    dec(16'h0341, 1, 0, "R10 stray writes leave window 1", 5'b00000);
    wr(11, 8'h04);
    dec(16'h0400, 1, 0, "R10 stop high byte at 0x0B", 5'b10110);

    // R11: window 1 start above stop, window 0 off
    wr(6, 8'h80);
    wr(12, 8'h50);
    dec(16'h0345, 1, 1, "R11 inverted window between", 5'b00000);
    dec(16'h0340, 1, 1, "R11 inverted window at stop", 5'b00000);
    dec(16'h0350, 1, 1, "R11 inverted window at start", 5'b00000);

    // R1: reset clears programmed state
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    wr(6, 8'hC0);
    dec(16'h0000, 1, 0, "R1 registers cleared by reset", 5'b10000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule